// File: doc/BRIEF.md
# On-chip Network Traffic and Latency Monitor

This block sits beside a network-on-chip endpoint and watches it without influencing it. It observes the start of each request and each flit moving on the request channel, the start of each response on the return channel, and the fill level of one FIFO of interest. From these it builds three kinds of performance statistics. The first is a throughput time series: the number of request flits in each fixed-length window of cycles. The second is the round-trip latency of every transaction, accumulated as a sum together with a transaction count. The third is the peak and the running sum of the FIFO fill level.

Each window produces a one-cycle sample pulse carrying its flit count. Latency is measured from the cycle a request starts to the cycle its response starts. Responses are paired with requests in issue order, so a small in-order queue of start timestamps lets several split transactions be in flight at once. Averages are left to the reader, who divides each sum by its count. Every accumulator saturates instead of wrapping and raises a sticky flag when it does. A synchronous start/clear input restarts every statistic.

Top module: `noc_perf_monitor`

## Requirements
- R1: While reset is asserted and after it is released, every output is zero until an event changes it.
- R2: Counting from the clock edge that samples `start_clr` high, `win_valid` is high for exactly one cycle after every WIN_LEN further edges. `win_flits` then holds the number of cycles within those WIN_LEN edges in which `req_flit` was high.
- R3: A flit presented in the cycle that `start_clr` is high is not counted. A flit in the first cycle after a window ends counts toward the next window, never the one just reported.
- R4: A window count that would exceed 2^CNT_W-1 is reported as 2^CNT_W-1. Bit 0 of `sat_flags` is then set and stays set.
- R5: For each `rsp_start`, the oldest unanswered `req_start` is removed. The difference in cycles between the two start cycles is added to `lat_sum`, and `lat_count` rises by one. The sum is updated on the same edge that samples `rsp_start`.
- R6: Up to TS_DEPTH requests can be outstanding. A `req_start` arriving when the queue is full and no response pops in that cycle is dropped, and `ts_overflow` is set and stays set.
- R7: An `rsp_start` with no outstanding request leaves `lat_sum` and `lat_count` unchanged.
- R8: Every edge with `start_clr` low samples `fifo_level`. `occ_peak` holds the largest level sampled, `occ_sum` holds the sum of the levels, and `occ_samples` holds the number of samples.
- R9: `lat_sum` and `occ_sum` saturate at their all-ones value and set bit 1 and bit 2 of `sat_flags`, respectively. `lat_count` and `occ_samples` saturate likewise and set bit 3. Every flag is sticky.
- R10: An edge with `start_clr` high returns every statistic, every flag and `ts_overflow` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_clr | input | 1 | Synchronous restart of all statistics |
| req_flit | input | 1 | A request flit is transferred this cycle |
| req_start | input | 1 | First cycle of a request |
| rsp_start | input | 1 | First cycle of a response |
| fifo_level | input | OCC_W | Fill level of the observed FIFO |
| win_valid | output | 1 | One-cycle pulse: a window sample is ready |
| win_flits | output | CNT_W | Flit count of the last completed window |
| lat_sum | output | ACC_W | Accumulated round-trip latency |
| lat_count | output | SMP_W | Number of completed latency measurements |
| occ_peak | output | OCC_W | Highest FIFO level observed |
| occ_sum | output | ACC_W | Sum of sampled FIFO levels |
| occ_samples | output | SMP_W | Number of FIFO level samples |
| sat_flags | output | 4 | Sticky saturation flags (bit 0 window, 1 latency sum, 2 occupancy sum, 3 a sample count) |
| ts_overflow | output | 1 | Sticky timestamp queue overflow |

## Verification
The latency and occupancy results are registered on the edge that samples the triggering input, so they can be read one step after that edge. A window sample is first visible after the edge that completes the window's WIN_LEN-th cycle. The bench drives each input just after a rising edge and reads the outputs one time unit after the next rising edge. Each expected value therefore belongs to exactly the edge that produced it. Every window length, latency and level pattern in the sweeps is counted in edges from the restart, and the expected sums are computed from those counts.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int SAT_WIN = 0;
  localparam int SAT_LAT = 1;
  localparam int SAT_OCC = 2;
  localparam int SAT_SMP = 3;
  localparam int NSAT    = 4;
endpackage

// File: rtl/perf_sat_acc.sv
module perf_sat_acc #(
  parameter int W    = 16,
  parameter int IN_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [IN_W-1:0] inc,
  output logic [W-1:0]    acc,
  output logic            sat
);
  localparam int SW = ((W > IN_W) ? W : IN_W) + 1;

  logic [W-1:0]  acc_q, acc_d;
  logic          sat_q, sat_d;
  logic [SW-1:0] sum_w;
  logic          ovf;

  always_comb begin
    sum_w = SW'(acc_q) + SW'(inc);
    ovf   = sum_w > SW'({W{1'b1}});
    acc_d = acc_q;
    sat_d = sat_q;
    if (clr) begin
      acc_d = '0;
      sat_d = 1'b0;
    end else if (en) begin
      acc_d = ovf ? {W{1'b1}} : sum_w[W-1:0];
      sat_d = sat_q | ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sat_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      sat_q <= sat_d;
    end
  end

  assign acc = acc_q;
  assign sat = sat_q;

  // R9: the flag stays once set
  p_sat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !clr) |=> sat_q);
  // R9: no wrap, the value never falls without a clear
  p_acc_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/perf_win_counter.sv
module perf_win_counter #(
  parameter int WIN_LEN = 100,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             flit,
  output logic             win_valid,
  output logic [CNT_W-1:0] win_flits,
  output logic             sat
);
  localparam int CYC_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CYC_W-1:0] LAST = CYC_W'(WIN_LEN - 1);

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [CNT_W-1:0] acc_q, acc_d, flits_q, flits_d, add_sat;
  logic [CNT_W:0]   add_w;
  logic             valid_q, valid_d, sat_q, sat_d, last, ovf;

  always_comb begin
    last    = (cyc_q == LAST);
    add_w   = {1'b0, acc_q} + (CNT_W+1)'(flit);
    ovf     = add_w[CNT_W];
    add_sat = ovf ? {CNT_W{1'b1}} : add_w[CNT_W-1:0];
    if (clr) begin
      cyc_d   = '0;
      acc_d   = '0;
      flits_d = '0;
      valid_d = 1'b0;
      sat_d   = 1'b0;
    end else begin
      cyc_d   = last ? '0 : cyc_q + 1'b1;
      acc_d   = last ? '0 : add_sat;
      flits_d = last ? add_sat : flits_q;
      valid_d = last;
      sat_d   = sat_q | ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      acc_q   <= '0;
      flits_q <= '0;
      valid_q <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      cyc_q   <= cyc_d;
      acc_q   <= acc_d;
      flits_q <= flits_d;
      valid_q <= valid_d;
      sat_q   <= sat_d;
    end
  end

  assign win_valid = valid_q;
  assign win_flits = flits_q;
  assign sat       = sat_q;

  // R2: a sample is a single-cycle pulse (WIN_LEN >= 2)
  p_win_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R2: a pulse always coincides with a fresh window start
  p_win_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (cyc_q == '0));
  // R4: window saturation flag is sticky
  p_win_sat_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !clr) |=> sat_q);
endmodule

// File: rtl/perf_lat_tracker.sv
module perf_lat_tracker #(
  parameter int TIME_W = 16,
  parameter int DEPTH  = 4,
  parameter int ACC_W  = 24,
  parameter int SMP_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             req_start,
  input  logic             rsp_start,
  output logic [ACC_W-1:0] lat_sum,
  output logic [SMP_W-1:0] lat_count,
  output logic             sum_sat,
  output logic             cnt_sat,
  output logic             overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [TIME_W-1:0] now_q, now_d;
  logic [TIME_W-1:0] ts_mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              full, pop, push, drop;
  logic [TIME_W-1:0] lat_val;

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    pop     = rsp_start && (cnt_q != '0) && !clr;
    push    = req_start && (!full || pop) && !clr;
    drop    = req_start && full && !pop && !clr;
    lat_val = now_q - ts_mem[rd_q];
    if (clr) begin
      now_d = '0;
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      now_d = now_q + 1'b1;
      wr_d  = push ? ((wr_q == PTR_LAST) ? '0 : wr_q + 1'b1) : wr_q;
      rd_d  = pop  ? ((rd_q == PTR_LAST) ? '0 : rd_q + 1'b1) : rd_q;
      cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
      ovf_d = ovf_q | drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      now_q <= now_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) ts_mem[wr_q] <= now_q;
  end

  perf_sat_acc #(.W(ACC_W), .IN_W(TIME_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(pop), .inc(lat_val),
    .acc(lat_sum), .sat(sum_sat));

  perf_sat_acc #(.W(SMP_W), .IN_W(1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(pop), .inc(1'b1),
    .acc(lat_count), .sat(cnt_sat));

  assign overflow = ovf_q;

  // R6: occupancy of the timestamp queue never exceeds its depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R6: a dropped request raises the flag on the next cycle
  p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);
  // R6: the overflow flag is sticky
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);
  // R7: an unmatched response changes no count
  p_orphan_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_start && cnt_q == '0 && !clr) |=> (lat_count == $past(lat_count)));
endmodule

// File: rtl/perf_occ_tracker.sv
module perf_occ_tracker #(
  parameter int OCC_W = 4,
  parameter int ACC_W = 24,
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [OCC_W-1:0] level,
  output logic [OCC_W-1:0] occ_peak,
  output logic [ACC_W-1:0] occ_sum,
  output logic [SMP_W-1:0] occ_samples,
  output logic             sum_sat,
  output logic             smp_sat
);
  logic [OCC_W-1:0] peak_q, peak_d;
  logic             take;

  always_comb begin
    take   = !clr;
    peak_d = peak_q;
    if (clr)                   peak_d = '0;
    else if (level > peak_q)   peak_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peak_q <= '0;
    else        peak_q <= peak_d;
  end

  perf_sat_acc #(.W(ACC_W), .IN_W(OCC_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(take), .inc(level),
    .acc(occ_sum), .sat(sum_sat));

  perf_sat_acc #(.W(SMP_W), .IN_W(1)) u_smp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(take), .inc(1'b1),
    .acc(occ_samples), .sat(smp_sat));

  assign occ_peak = peak_q;

  // R8: the peak covers every level sampled
  p_peak_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (peak_q >= $past(level)));
endmodule

// File: rtl/noc_perf_monitor.sv
module noc_perf_monitor
  import perf_mon_pkg::*;
#(
  parameter int WIN_LEN  = 100,
  parameter int CNT_W    = 8,
  parameter int TIME_W   = 16,
  parameter int TS_DEPTH = 4,
  parameter int ACC_W    = 24,
  parameter int SMP_W    = 16,
  parameter int OCC_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_clr,
  input  logic             req_flit,
  input  logic             req_start,
  input  logic             rsp_start,
  input  logic [OCC_W-1:0] fifo_level,
  output logic             win_valid,
  output logic [CNT_W-1:0] win_flits,
  output logic [ACC_W-1:0] lat_sum,
  output logic [SMP_W-1:0] lat_count,
  output logic [OCC_W-1:0] occ_peak,
  output logic [ACC_W-1:0] occ_sum,
  output logic [SMP_W-1:0] occ_samples,
  output logic [3:0]       sat_flags,
  output logic             ts_overflow
);
  logic win_sat, lat_sum_sat, lat_cnt_sat, occ_sum_sat, occ_smp_sat;

  perf_win_counter #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(start_clr), .flit(req_flit),
    .win_valid(win_valid), .win_flits(win_flits), .sat(win_sat));

  perf_lat_tracker #(.TIME_W(TIME_W), .DEPTH(TS_DEPTH), .ACC_W(ACC_W),
                     .SMP_W(SMP_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(start_clr), .req_start(req_start),
    .rsp_start(rsp_start), .lat_sum(lat_sum), .lat_count(lat_count),
    .sum_sat(lat_sum_sat), .cnt_sat(lat_cnt_sat), .overflow(ts_overflow));

  perf_occ_tracker #(.OCC_W(OCC_W), .ACC_W(ACC_W), .SMP_W(SMP_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(start_clr), .level(fifo_level),
    .occ_peak(occ_peak), .occ_sum(occ_sum), .occ_samples(occ_samples),
    .sum_sat(occ_sum_sat), .smp_sat(occ_smp_sat));

  always_comb begin
    sat_flags          = '0;
    sat_flags[SAT_WIN] = win_sat;
    sat_flags[SAT_LAT] = lat_sum_sat;
    sat_flags[SAT_OCC] = occ_sum_sat;
    sat_flags[SAT_SMP] = lat_cnt_sat | occ_smp_sat;
  end

  // R10: a restart clears every flag on the next cycle
  p_clear_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> (sat_flags == '0 && !ts_overflow));
  // R1: nothing is reported right after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!win_valid && lat_count == '0));
endmodule

// File: tb/sim_noc_perf_monitor.sv
`timescale 1ns/1ps
module sim_noc_perf_monitor;
  localparam int WL = 8, CW = 3, TW = 8, DP = 2, AW = 6, SW = 6, OW = 3;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, flit = 1'b0, rq = 1'b0, rs = 1'b0;
  logic [OW-1:0] lvl = '0;
  logic          win_valid, ts_overflow;
  logic [CW-1:0] win_flits;
  logic [AW-1:0] lat_sum, occ_sum;
  logic [SW-1:0] lat_count, occ_samples;
  logic [OW-1:0] occ_peak;
  logic [3:0]    sat_flags;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  noc_perf_monitor #(.WIN_LEN(WL), .CNT_W(CW), .TIME_W(TW), .TS_DEPTH(DP),
                     .ACC_W(AW), .SMP_W(SW), .OCC_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_clr(clr), .req_flit(flit),
    .req_start(rq), .rsp_start(rs), .fifo_level(lvl),
    .win_valid(win_valid), .win_flits(win_flits), .lat_sum(lat_sum),
    .lat_count(lat_count), .occ_peak(occ_peak), .occ_sum(occ_sum),
    .occ_samples(occ_samples), .sat_flags(sat_flags), .ts_overflow(ts_overflow));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic f, input logic a, input logic b,
                      input int l, input logic c);
    flit = f; rq = a; rs = b; lvl = OW'(l); clr = c;
    @(posedge clk); #1;
    flit = 1'b0; rq = 1'b0; rs = 1'b0; clr = 1'b0;
  endtask

  task automatic restart();
    tick(1'b0, 1'b0, 1'b0, 0, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    check("R1 win_valid", win_valid, 0);
    check("R1 lat_sum", lat_sum, 0);
    check("R1 occ_samples", occ_samples, 0);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 flags", sat_flags, 0);
    check("R1 ts_overflow", ts_overflow, 0);

    // R2/R4: sweep n = 0..8 flits per window, consecutive windows
    restart();
    for (int n = 0; n <= WL; n++) begin
      for (int i = 0; i < WL; i++) begin
        tick(i < n, 1'b0, 1'b0, 0, 1'b0);
        if (i < WL - 1) check("R2 no pulse mid window", win_valid, 0);
      end
      check("R2 pulse at window end", win_valid, 1);
      check("R2 R4 window count", win_flits, (n > 7) ? 7 : n);
      check("R4 window sat flag", sat_flags[0], (n == WL) ? 1 : 0);
    end

    // R3: flit during restart is not counted; one late flit belongs to next
    tick(1'b1, 1'b0, 1'b0, 0, 1'b1);
    for (int i = 0; i < WL; i++) tick(1'b0, 1'b0, 1'b0, 0, 1'b0);
    check("R3 restart flit ignored", win_flits, 0);
    check("R10 window flag cleared", sat_flags[0], 0);
    tick(1'b1, 1'b0, 1'b0, 0, 1'b0);
    for (int i = 1; i < WL; i++) tick(1'b0, 1'b0, 1'b0, 0, 1'b0);
    check("R3 first-cycle flit in new window", win_flits, 1);

    // R5: single transactions with latency 1..5
    restart();
    for (int l = 1; l <= 5; l++) begin
      tick(1'b0, 1'b1, 1'b0, 0, 1'b0);
      for (int k = 1; k < l; k++) tick(1'b0, 1'b0, 1'b0, 0, 1'b0);
      tick(1'b0, 1'b0, 1'b1, 0, 1'b0);
      check("R5 latency sum", lat_sum, l * (l + 1) / 2);
      check("R5 latency count", lat_count, l);
    end

    // R5: two split transactions in flight, paired in order
    restart();
    tick(1'b0, 1'b1, 1'b0, 0, 1'b0);        // step 0
    tick(1'b0, 1'b1, 1'b0, 0, 1'b0);        // step 1
    tick(1'b0, 1'b0, 1'b0, 0, 1'b0);        // step 2
    tick(1'b0, 1'b0, 1'b1, 0, 1'b0);        // step 3 -> 3
    tick(1'b0, 1'b0, 1'b0, 0, 1'b0);        // step 4
    tick(1'b0, 1'b0, 1'b1, 0, 1'b0);        // step 5 -> 4
    check("R5 split sum", lat_sum, 7);
    check("R5 split count", lat_count, 2);
    check("R6 no overflow at depth", ts_overflow, 0);

    // R6/R7: third outstanding request overflows; orphan response ignored
    restart();
    tick(1'b0, 1'b1, 1'b0, 0, 1'b0);        // step 0
    tick(1'b0, 1'b1, 1'b0, 0, 1'b0);        // step 1
    tick(1'b0, 1'b1, 1'b0, 0, 1'b0);        // step 2 dropped
    check("R6 overflow flag", ts_overflow, 1);
    tick(1'b0, 1'b0, 1'b0, 0, 1'b0);        // step 3
    tick(1'b0, 1'b0, 1'b1, 0, 1'b0);        // step 4 -> 4
    tick(1'b0, 1'b0, 1'b1, 0, 1'b0);        // step 5 -> 4
    check("R6 kept entries sum", lat_sum, 8);
    tick(1'b0, 1'b0, 1'b1, 0, 1'b0);        // step 6 orphan
    check("R7 orphan count", lat_count, 2);
    check("R7 orphan sum", lat_sum, 8);
    check("R6 overflow sticky", ts_overflow, 1);

    // R9: latency sum saturates (40 + 40 > 63)
    restart();
    for (int t = 0; t < 2; t++) begin
      tick(1'b0, 1'b1, 1'b0, 0, 1'b0);
      for (int k = 1; k < 40; k++) tick(1'b0, 1'b0, 1'b0, 0, 1'b0);
      tick(1'b0, 1'b0, 1'b1, 0, 1'b0);
    end
    check("R9 latency sum saturated", lat_sum, 63);
    check("R9 latency sat flag", sat_flags[1], 1);

    // R8: occupancy peak, sum, samples
    restart();
    tick(1'b0, 1'b0, 1'b0, 1, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 4, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 2, 1'b0);
    check("R8 peak", occ_peak, 4);
    check("R8 sum", occ_sum, 7);
    check("R8 samples", occ_samples, 3);
    // R9: occupancy sum saturates
    for (int k = 0; k < 10; k++) tick(1'b0, 1'b0, 1'b0, 7, 1'b0);
    check("R8 peak at max", occ_peak, 7);
    check("R9 occ sum saturated", occ_sum, 63);
    check("R9 occ sat flag", sat_flags[2], 1);
    check("R9 sample flag not yet", sat_flags[3], 0);
    for (int k = 0; k < 55; k++) tick(1'b0, 1'b0, 1'b0, 0, 1'b0);
    check("R9 samples saturated", occ_samples, 63);
    check("R9 sample sat flag", sat_flags[3], 1);
    check("R9 occ sum held", occ_sum, 63);

    // R10: restart clears everything
    tick(1'b0, 1'b1, 1'b0, 5, 1'b1);
    check("R10 occ_sum", occ_sum, 0);
    check("R10 occ_peak", occ_peak, 0);
    check("R10 samples", occ_samples, 0);
    check("R10 flags", sat_flags, 0);
    check("R10 lat_count", lat_count, 0);
    tick(1'b0, 1'b0, 1'b1, 0, 1'b0);
    check("R10 request during restart not queued", lat_count, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule